// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the registered arithmetic and logic core of a small 8-bit accumulator processor. It keeps an accumulator, two index registers, a status byte and a result byte. In each clock cycle it may take one operation code and one operand byte from memory. If the enable input is high, the operation updates the registers at the clock edge. If the enable input is low, every register keeps its value.

The operations are add with carry, AND, shift left of either the accumulator or the operand, bit test, break, and four flag clears. A branch code passes through and changes nothing. Codes that are not assigned also change nothing. The result, status, X and Y registers drive the outputs directly. The accumulator has no output of its own; an AND with operand 0xFF copies it onto the result.

Operation codes on `opc_i`:

| Code | Operation |
|------|-----------|
| 0x1 | add with carry |
| 0x2 | AND |
| 0x3 | shift accumulator |
| 0x4 | shift operand |
| 0x5 | bit test |
| 0x6 | break |
| 0x7 | clear carry |
| 0x8 | clear interrupt mask |
| 0x9 | clear decimal |
| 0xA | clear overflow |
| 0xB | branch |
| 0x0, 0xC to 0xF | unassigned |

Status bit positions are fixed:

| Bit | Flag |
|-----|------|
| 0 | carry (C) |
| 1 | zero (Z) |
| 2 | interrupt mask (I) |
| 3 | decimal (D) |
| 4 | break (B) |
| 5 | constant 1 |
| 6 | overflow (V) |
| 7 | negative (N) |

Top module: `acc_alu8`

## Requirements
- R1: Reset is synchronous and has priority over the enable input. One edge with `rst_i` high sets the accumulator, result, X and Y to 0 and sets status to 0x22. It does this even when the enable input is high and a valid operation is applied.
- R2: X and Y read 0 after reset, and no operation changes them. Status bit 5 stays 1.
- R3: With code 0x1 (add with carry), the accumulator and the result both take the low 8 bits of A + M + C. Status bit 0 becomes 1 exactly when that 9-bit sum is above 255.
- R4: With code 0x1, status bit 6 becomes 1 exactly when the sum, read as a signed number, falls outside the range -128 to 127.
- R5: With code 0x2 (AND), the accumulator and the result both take A & M.
- R6: With code 0x3 (shift accumulator), status bit 0 takes the old A bit 7. The accumulator becomes A shifted left by one with a 0 entering bit 0. The result takes the same value.
- R7: With code 0x4 (shift operand), status bit 0 takes M bit 7 and the result takes M shifted left by one. The accumulator does not change.
- R8: With code 0x5 (bit test), status bit 1 is set exactly when A & M is 0, bit 7 takes M bit 7 and bit 6 takes M bit 6. The accumulator and the result do not change.
- R9: With code 0x6 (break), status bit 4 is set. No other bit and no register changes.
- R10: Each clear code clears only its own status bit: 0x7 clears bit 0, 0x8 clears bit 2, 0x9 clears bit 3 and 0xA clears bit 6.
- R11: Code 0xB (branch) changes no register and no flag.
- R12: Codes 0x0 and 0xC to 0xF change no register and no flag.
- R13: While `en_i` is low, every register holds its value whatever code and operand are applied.
- R14: For codes 0x1 to 0x4, status bit 1 is set exactly when the 8-bit value written to the result is 0. Status bit 7 equals bit 7 of that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Executes the applied code when high |
| opc_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand byte from memory |
| result_o | output | 8 | Result register |
| status_o | output | 8 | Status register |
| xreg_o | output | 8 | X index register |
| yreg_o | output | 8 | Y index register |

## Verification
In an add, the carry out of bit 7 and the signed overflow can both occur on the same edge, and the zero flag may be set on that edge as well. The bench provokes this in two ways. It adds 0x80 to an accumulator that holds 0x80, which sets carry, overflow and zero together. It adds two negative values whose sum is positive. In both cases the whole status byte is compared against a reference model. The reference model computes carry from an integer sum and overflow from a signed range test.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
  localparam int DATA_W = 8;
  localparam int OPC_W  = 4;

  // Status bit positions; the bit map is visible at the ports.
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_I = 2;
  localparam int FLG_D = 3;
  localparam int FLG_B = 4;
  localparam int FLG_V = 6;
  localparam int FLG_N = 7;

  localparam logic [DATA_W-1:0] STATUS_RST = 8'b0010_0010;

  localparam logic [OPC_W-1:0] OPC_ADC   = 4'h1;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_SHLA  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_SHLM  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_BTST  = 4'h5;
  localparam logic [OPC_W-1:0] OPC_BRK   = 4'h6;
  localparam logic [OPC_W-1:0] OPC_CLRC  = 4'h7;
  localparam logic [OPC_W-1:0] OPC_CLRI  = 4'h8;
  localparam logic [OPC_W-1:0] OPC_CLRD  = 4'h9;
  localparam logic [OPC_W-1:0] OPC_CLRV  = 4'hA;
  localparam logic [OPC_W-1:0] OPC_BRNCH = 4'hB;

  // One-hot operation selects produced by the decoder.
  typedef struct packed {
    logic adc;
    logic andm;
    logic shl_a;
    logic shl_m;
    logic btst;
    logic brk;
    logic clr_c;
    logic clr_i;
    logic clr_d;
    logic clr_v;
    logic branch;
  } ctl_t;

  // Sum with the carry out in the top bit.
  function automatic logic [DATA_W:0] add_carry(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b,
                                                input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  // Signed overflow: both inputs share a sign and the sum has the other sign.
  function automatic logic sgn_ovf(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic [DATA_W-1:0] s);
    return (a[DATA_W-1] == b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
  endfunction

  // Shift left by one; the bit shifted out lands in the top bit.
  function automatic logic [DATA_W:0] shl1(input logic [DATA_W-1:0] v);
    return {v, 1'b0};
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return v == '0;
  endfunction
endpackage

// File: rtl/acc_alu8_dec.sv
module acc_alu8_dec
  import acc_alu8_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opc_i,
  output ctl_t          ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (opc_i)
      OPC_ADC:   ctl_o.adc    = 1'b1;
      OPC_AND:   ctl_o.andm   = 1'b1;
      OPC_SHLA:  ctl_o.shl_a  = 1'b1;
      OPC_SHLM:  ctl_o.shl_m  = 1'b1;
      OPC_BTST:  ctl_o.btst   = 1'b1;
      OPC_BRK:   ctl_o.brk    = 1'b1;
      OPC_CLRC:  ctl_o.clr_c  = 1'b1;
      OPC_CLRI:  ctl_o.clr_i  = 1'b1;
      OPC_CLRD:  ctl_o.clr_d  = 1'b1;
      OPC_CLRV:  ctl_o.clr_v  = 1'b1;
      OPC_BRNCH: ctl_o.branch = 1'b1;
      default:   ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu8_dp.sv
module acc_alu8_dp
  import acc_alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  ctl_t         ctl_i,
  input  logic [W-1:0] acc_q_i,
  input  logic [W-1:0] res_q_i,
  input  logic [W-1:0] st_q_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] acc_d_o,
  output logic [W-1:0] res_d_o,
  output logic [W-1:0] st_d_o,
  output logic         evt_carry_o,
  output logic         evt_ovf_o
);
  logic [W:0]   sum_w;
  logic [W:0]   shl_acc_w;
  logic [W:0]   shl_mem_w;
  logic [W-1:0] and_w;
  logic [W-1:0] val_w;
  logic         upd_zn_w;

  assign sum_w     = add_carry(acc_q_i, opnd_i, st_q_i[FLG_C]);
  assign shl_acc_w = shl1(acc_q_i);
  assign shl_mem_w = shl1(opnd_i);
  assign and_w     = acc_q_i & opnd_i;

  // The carry and overflow each op would produce, brought out for the checker.
  assign evt_carry_o = ctl_i.adc   ? sum_w[W] :
                       ctl_i.shl_a ? shl_acc_w[W] :
                       ctl_i.shl_m ? shl_mem_w[W] : st_q_i[FLG_C];
  assign evt_ovf_o   = ctl_i.adc ? sgn_ovf(acc_q_i, opnd_i, sum_w[W-1:0]) : st_q_i[FLG_V];

  // The value that feeds the zero and negative flags.
  always_comb begin
    val_w    = res_q_i;
    upd_zn_w = 1'b1;
    if (ctl_i.adc)        val_w = sum_w[W-1:0];
    else if (ctl_i.andm)  val_w = and_w;
    else if (ctl_i.shl_a) val_w = shl_acc_w[W-1:0];
    else if (ctl_i.shl_m) val_w = shl_mem_w[W-1:0];
    else                  upd_zn_w = 1'b0;
  end

  always_comb begin
    acc_d_o = acc_q_i;
    res_d_o = res_q_i;
    st_d_o  = st_q_i;
    if (ctl_i.adc || ctl_i.andm || ctl_i.shl_a) acc_d_o = val_w;
    if (upd_zn_w) begin
      res_d_o       = val_w;
      st_d_o[FLG_Z] = is_zero(val_w);
      st_d_o[FLG_N] = val_w[W-1];
    end
    if (ctl_i.adc || ctl_i.shl_a || ctl_i.shl_m) st_d_o[FLG_C] = evt_carry_o;
    if (ctl_i.adc) st_d_o[FLG_V] = evt_ovf_o;
    if (ctl_i.btst) begin
      st_d_o[FLG_Z] = is_zero(and_w);
      st_d_o[FLG_N] = opnd_i[W-1];
      st_d_o[FLG_V] = opnd_i[W-2];
    end
    if (ctl_i.brk)   st_d_o[FLG_B] = 1'b1;
    if (ctl_i.clr_c) st_d_o[FLG_C] = 1'b0;
    if (ctl_i.clr_i) st_d_o[FLG_I] = 1'b0;
    if (ctl_i.clr_d) st_d_o[FLG_D] = 1'b0;
    if (ctl_i.clr_v) st_d_o[FLG_V] = 1'b0;
  end
endmodule

// File: rtl/acc_alu8_regs.sv
module acc_alu8_regs
  import acc_alu8_pkg::*;
#(
  parameter int           W      = DATA_W,
  parameter logic [W-1:0] RST_ST = STATUS_RST
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] acc_d_i,
  input  logic [W-1:0] res_d_i,
  input  logic [W-1:0] st_d_i,
  output logic [W-1:0] acc_q_o,
  output logic [W-1:0] res_q_o,
  output logic [W-1:0] st_q_o,
  output logic [W-1:0] x_q_o,
  output logic [W-1:0] y_q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q_o <= '0;
      res_q_o <= '0;
    end else if (en_i) begin
      acc_q_o <= acc_d_i;
      res_q_o <= res_d_i;
    end
  end

  // No operation in scope writes the index registers.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      x_q_o <= '0;
      y_q_o <= '0;
    end
  end

  // Each status bit has its own flop, loaded from its own reset value.
  for (genvar i = 0; i < W; i++) begin : g_st
    logic bit_q;
    always_ff @(posedge clk_i) begin
      if (rst_i)     bit_q <= RST_ST[i];
      else if (en_i) bit_q <= st_d_i[i];
    end
    assign st_q_o[i] = bit_q;
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                en_i,
  input  logic [OPC_W-1:0]    opc_i,
  input  logic [DATA_W-1:0]   opnd_i,
  output logic [DATA_W-1:0]   result_o,
  output logic [DATA_W-1:0]   status_o,
  output logic [DATA_W-1:0]   xreg_o,
  output logic [DATA_W-1:0]   yreg_o
);
  ctl_t              ctl;
  logic [DATA_W-1:0] acc_q, res_q, st_q;
  logic [DATA_W-1:0] acc_d, res_d, st_d;
  logic              evt_carry, evt_ovf;

  acc_alu8_dec #(.OW(OPC_W)) u_dec (
    .opc_i (opc_i),
    .ctl_o (ctl)
  );

  acc_alu8_dp #(.W(DATA_W)) u_dp (
    .ctl_i       (ctl),
    .acc_q_i     (acc_q),
    .res_q_i     (res_q),
    .st_q_i      (st_q),
    .opnd_i      (opnd_i),
    .acc_d_o     (acc_d),
    .res_d_o     (res_d),
    .st_d_o      (st_d),
    .evt_carry_o (evt_carry),
    .evt_ovf_o   (evt_ovf)
  );

  acc_alu8_regs #(.W(DATA_W), .RST_ST(STATUS_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .acc_d_i (acc_d),
    .res_d_i (res_d),
    .st_d_i  (st_d),
    .acc_q_o (acc_q),
    .res_q_o (res_q),
    .st_q_o  (st_q),
    .x_q_o   (xreg_o),
    .y_q_o   (yreg_o)
  );

  assign result_o = res_q;
  assign status_o = st_q;
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [3:0] opc,
  input logic [7:0] result,
  input logic [7:0] status,
  input logic [7:0] xr,
  input logic [7:0] yr,
  input logic       evt_carry,
  input logic       evt_ovf
);
  // R1: reset values, even while enable is high
  a_r1_reset_vals: assert property (@(posedge clk)
    rst |=> (result == 8'h00 && status == 8'h22 && xr == 8'h00 && yr == 8'h00));

  // R2: index registers stay zero and status bit 5 stays 1
  a_r2_idx_const: assert property (@(posedge clk) disable iff (rst)
    (xr == 8'h00 && yr == 8'h00 && status[5]));

  // R3: the add writes the carry it generated
  a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
    (en && opc == 4'h1) |=> status[0] == $past(evt_carry));

  // R4: the add writes the overflow it generated
  a_r4_add_ovf: assert property (@(posedge clk) disable iff (rst)
    (en && opc == 4'h1) |=> status[6] == $past(evt_ovf));

  // R14: Z and N follow the value written to the result
  a_r14_zn_follow: assert property (@(posedge clk) disable iff (rst)
    (en && opc >= 4'h1 && opc <= 4'h4) |=>
      (status[1] == (result == 8'h00) && status[7] == result[7]));

  // R11: branch code has no effect
  a_r11_branch_idle: assert property (@(posedge clk) disable iff (rst)
    (en && opc == 4'hB) |=> ($stable(result) && $stable(status)));

  // R12: unassigned codes have no effect
  a_r12_unknown_idle: assert property (@(posedge clk) disable iff (rst)
    (en && (opc == 4'h0 || opc >= 4'hC)) |=> ($stable(result) && $stable(status)));

  // R13: enable low holds all state
  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result) && $stable(status)));
endmodule

bind acc_alu8 acc_alu8_chk u_chk (
  .clk       (clk_i),
  .rst       (rst_i),
  .en        (en_i),
  .opc       (opc_i),
  .result    (result_o),
  .status    (status_o),
  .xr        (xreg_o),
  .yr        (yreg_o),
  .evt_carry (evt_carry),
  .evt_ovf   (evt_ovf)
);

// File: tb/acc_alu8_test.sv
`timescale 1ns/1ps
module acc_alu8_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] opc = 4'h0;
  logic [7:0] opnd = 8'h00;
  logic [7:0] result, status, xreg, yreg;

  int n_chk = 0;
  int n_err = 0;

  // Reference state
  logic [7:0] m_a, m_res, m_st;

  always #5 clk = ~clk;

  acc_alu8 uut (
    .clk_i    (clk),
    .rst_i    (rst),
    .en_i     (en),
    .opc_i    (opc),
    .opnd_i   (opnd),
    .result_o (result),
    .status_o (status),
    .xreg_o   (xreg),
    .yreg_o   (yreg)
  );

  task automatic check(input string tag);
    n_chk++;
    if (result !== m_res || status !== m_st || xreg !== 8'h00 || yreg !== 8'h00) begin
      n_err++;
      $display("FAIL %s: got res=%h st=%h x=%h y=%h, expected res=%h st=%h x=00 y=00",
               tag, result, status, xreg, yreg, m_res, m_st);
    end
  endtask

  task automatic set_zn(input logic [7:0] v);
    m_st[1] = (v == 8'h00);
    m_st[7] = (v >= 8'h80);
  endtask

  // Reference update from the requirements, written with integer arithmetic.
  task automatic model(input logic [3:0] op, input logic [7:0] m);
    int s;
    int sv;
    case (op)
      4'h1: begin
        s  = int'(m_a) + int'(m) + int'(m_st[0]);
        sv = int'($signed(m_a)) + int'($signed(m)) + int'(m_st[0]);
        m_a = s[7:0];
        m_res = m_a;
        m_st[0] = (s > 255);
        m_st[6] = (sv > 127) || (sv < -128);
        set_zn(m_a);
      end
      4'h2: begin m_a = m_a & m; m_res = m_a; set_zn(m_a); end
      4'h3: begin
        m_st[0] = m_a[7];
        s = int'(m_a) * 2;
        m_a = s[7:0];
        m_res = m_a;
        set_zn(m_a);
      end
      4'h4: begin
        m_st[0] = m[7];
        s = int'(m) * 2;
        m_res = s[7:0];
        set_zn(m_res);
      end
      4'h5: begin
        m_st[1] = ((m_a & m) == 8'h00);
        m_st[7] = m[7];
        m_st[6] = m[6];
      end
      4'h6: m_st[4] = 1'b1;
      4'h7: m_st[0] = 1'b0;
      4'h8: m_st[2] = 1'b0;
      4'h9: m_st[3] = 1'b0;
      4'hA: m_st[6] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] m, input logic e,
                      input string tag);
    @(negedge clk);
    opc = op; opnd = m; en = e;
    if (e) model(op, m);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  // Sets the accumulator to v and leaves carry cleared.
  task automatic load_acc(input logic [7:0] v);
    step(4'h2, 8'h00, 1'b1, "R5");
    step(4'h7, 8'h00, 1'b1, "R10");
    step(4'h1, v,     1'b1, "R3");
  endtask

  task automatic t_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; en = 1'b1; opc = 4'h1; opnd = 8'hFF;
    @(posedge clk);
    @(posedge clk);
    #1;
    m_a = 8'h00; m_res = 8'h00; m_st = 8'h22;
    check(tag);
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
  endtask

  task automatic t_adc;
    load_acc(8'h10);
    step(4'h1, 8'h25, 1'b1, "R3");
    step(4'h1, 8'h50, 1'b1, "R4");   // 0x35+0x50: overflow, negative
    step(4'h1, 8'h85, 1'b1, "R4");   // two negatives sum positive, carry
    step(4'h1, 8'h01, 1'b1, "R3");   // carry in used
    load_acc(8'h80);
    step(4'h1, 8'h80, 1'b1, "R14");  // carry, overflow and zero together
    step(4'h1, 8'hFF, 1'b1, "R3");   // 0+FF+1 wraps to zero
  endtask

  task automatic t_and;
    load_acc(8'hF0);
    step(4'h2, 8'h3C, 1'b1, "R5");
    step(4'h2, 8'h0F, 1'b1, "R14");
  endtask

  task automatic t_shl_acc;
    load_acc(8'hC1);
    step(4'h3, 8'h00, 1'b1, "R6");
    step(4'h3, 8'hFF, 1'b1, "R6");
    step(4'h3, 8'h00, 1'b1, "R6");
    load_acc(8'h80);
    step(4'h3, 8'h00, 1'b1, "R14");
  endtask

  task automatic t_shl_mem;
    load_acc(8'h11);
    step(4'h4, 8'h81, 1'b1, "R7");
    step(4'h4, 8'h40, 1'b1, "R7");
    step(4'h2, 8'hFF, 1'b1, "R7");   // accumulator still 0x11
  endtask

  task automatic t_bit;
    load_acc(8'h0F);
    step(4'h5, 8'hC0, 1'b1, "R8");
    step(4'h5, 8'h01, 1'b1, "R8");
    step(4'h5, 8'h40, 1'b1, "R8");
    step(4'h2, 8'hFF, 1'b1, "R8");   // accumulator unchanged
  endtask

  task automatic t_brk_clr;
    step(4'h6, 8'h00, 1'b1, "R9");
    load_acc(8'h80);
    step(4'h1, 8'h80, 1'b1, "R4");   // carry and overflow set
    step(4'hA, 8'h00, 1'b1, "R10");
    step(4'h8, 8'h00, 1'b1, "R10");
    step(4'h9, 8'h00, 1'b1, "R10");
    step(4'h7, 8'h00, 1'b1, "R10");
  endtask

  task automatic t_branch_unknown;
    load_acc(8'h7F);
    step(4'h1, 8'h01, 1'b1, "R4");
    step(4'hB, 8'hAA, 1'b1, "R11");
    step(4'h0, 8'h55, 1'b1, "R12");
    for (int k = 12; k < 16; k++) step(4'(k), 8'h55, 1'b1, "R12");
    step(4'h2, 8'hFF, 1'b1, "R12");  // accumulator untouched
  endtask

  task automatic t_hold;
    load_acc(8'h21);
    step(4'h1, 8'h33, 1'b0, "R13");
    step(4'h3, 8'h00, 1'b0, "R13");
    step(4'h6, 8'h00, 1'b0, "R13");
    step(4'h2, 8'hFF, 1'b1, "R13");  // accumulator still 0x21
  endtask

  task automatic t_index;
    step(4'h1, 8'hFF, 1'b1, "R2");
    step(4'h3, 8'hFF, 1'b1, "R2");
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset("R1");
    t_adc;
    t_and;
    t_shl_acc;
    t_shl_mem;
    t_bit;
    t_brk_clr;
    t_branch_unknown;
    t_hold;
    t_index;
    t_reset("R1");
    t_index;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule